// File: doc/BRIEF.md
# Peripheral DMA Handshake Sequencer

This block runs the peripheral side of one single-word DMA bus cycle. When a cycle is started, it acknowledges the requesting channel. Its state machine then decides whether the I/O port takes part in a handshake or whether the cycle simply ends on memory ready.

On a memory-read cycle the port is given a write strobe once memory data is valid. The cycle ends only when the port withdraws its request. On a memory-write cycle the port drives data while it is acknowledged. The block waits for the port to withdraw its request, raises a capture strobe, and ends the cycle on memory ready.

A watchdog counts waiting clocks and aborts a cycle that stalls for too long, unless the timeout-disable input is held low. A request that has been idle for two or more sampled clocks at the decision point causes the handshake to be skipped. This covers cycles started by software with no external request present.

Top module: `dmaPortHandshake`

## Requirements
- R1: After reset, chanAckN, portWrStbN and portRdStbN are high, and cycleDone and timeoutErr are low.
- R2: A cycStart pulse while no cycle runs drives chanAckN low at that clock edge. A cycStart during a running cycle has no effect on any output.
- R3: On a read cycle (memRead=1) with the handshake active, memReadyN sampled low drives portWrStbN low at that edge. portWrStbN then stays low while chanReqN remains sampled low.
- R4: In the read handshake, the first edge at which chanReqN is seen high raises chanAckN and portWrStbN together and ends the cycle. chanReqN is sampled on the falling clock edge, so a change made after a rising edge is seen at the next rising edge.
- R5: On a write cycle (memRead=0) with the handshake active, the block waits for chanReqN to be seen high and then drives portRdStbN low. The next edge with memReadyN low raises chanAckN and portRdStbN and ends the cycle.
- R6: The handshake is bypassed if chanReqN was seen high at the decision edge and at the edge before it. For a read the decision edge is the ready edge; for a write it is the second edge of the cycle. A bypassed cycle never lowers a port strobe and ends on the first edge with memReadyN low.
- R7: cycleDone is a one-clock high pulse, given exactly once per completed cycle on the edge that raises chanAckN.
- R8: With timeoutDisN high, the waiting count starts at zero for each cycle. Waiting means an edge that waits on memReadyN or on chanReqN. The 257th consecutive waiting edge aborts the cycle: chanAckN and both strobes go high, timeoutErr goes high, and no cycleDone is given. timeoutErr stays high until the next cycle start.
- R9: While timeoutDisN is low, the waiting count is held at zero and no timeout occurs, however long the cycle waits.
- R10: With memReadyN already low and no request, the shortest cycle has chanAckN low for two clocks. cycleDone appears on the second edge after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycStart | input | 1 | One-clock pulse that opens a cycle |
| memRead | input | 1 | 1 = memory read, port receives; 0 = memory write, port sends |
| chanReqN | input | 1 | Channel request from the port, active low, sampled on the falling edge |
| memReadyN | input | 1 | Memory ready, active low |
| timeoutDisN | input | 1 | Low clears and disables the timeout counter |
| chanAckN | output | 1 | Channel acknowledge, active low |
| portWrStbN | output | 1 | Strobe for the port to take read data, active low |
| portRdStbN | output | 1 | Strobe marking port data captured for memory, active low |
| cycleDone | output | 1 | One-clock pulse at cycle completion |
| timeoutErr | output | 1 | Timeout abort flag, held until the next start |

## Verification
The hardest situations to reach are the two boundaries. One is the request released exactly one or exactly two sampled clocks before the ready edge, which decides handshake against bypass. The other is a wait of exactly 256 against 257 waiting edges. Directed cycles place the request release and the ready edge at these exact offsets from the start pulse. Seeded random cycles then vary the direction, the wait lengths, extra start pulses and the timeout disable around them.

// File: rtl/dmaPortHandshake_pkg.sv
package dmaPortHandshake_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_HOLD,
    ST_WREQ
  } hsState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrTimer;
    logic incTimer;
    logic latchDir;
    logic setAck;
    logic relAll;
    logic setPortWr;
    logic setPortRd;
    logic pulseDone;
    logic setErr;
    logic clrErr;
  } hsCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic reqActive;
    logic bypassOk;
    logic timerAtLimit;
    logic isRead;
  } hsStat_t;

endpackage

// File: rtl/dmaPortHandshake_dp.sv
module dmaPortHandshake_dp
  import dmaPortHandshake_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 256,
  parameter int BYPASS_CLKS  = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    chanReqN,
  input  logic    memRead,
  input  logic    timeoutDisN,
  input  hsCtrl_t ctrl,
  output hsStat_t stat,
  output logic    chanAckN,
  output logic    portWrStbN,
  output logic    portRdStbN,
  output logic    cycleDone,
  output logic    timeoutErr
);

  localparam int TW  = $clog2(TIMEOUT_CLKS + 1);
  localparam int RCW = (BYPASS_CLKS > 2) ? $clog2(BYPASS_CLKS) : 1;
  localparam logic [RCW-1:0] REL_SAT = RCW'(BYPASS_CLKS - 1);
  localparam logic [TW-1:0]  T_LIM   = TW'(TIMEOUT_CLKS);

  logic            reqSampled;
  logic [RCW-1:0]  relCnt;
  logic [TW-1:0]   waitTimer;
  logic            rdMode;

  // port request captured on the falling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) reqSampled <= 1'b0;
    else       reqSampled <= !chanReqN;
  end

  // consecutive rising-edge samples with the request released
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           relCnt <= '0;
    else if (reqSampled) relCnt <= '0;
    else if (relCnt != REL_SAT) relCnt <= relCnt + RCW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              waitTimer <= '0;
    else if (!timeoutDisN)  waitTimer <= '0;
    else if (ctrl.clrTimer) waitTimer <= '0;
    else if (ctrl.incTimer) waitTimer <= waitTimer + TW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdMode <= 1'b1;
    else if (ctrl.latchDir) rdMode <= memRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanAckN   <= 1'b1;
      portWrStbN <= 1'b1;
      portRdStbN <= 1'b1;
      cycleDone  <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      cycleDone <= ctrl.pulseDone;
      if (ctrl.setAck)    chanAckN   <= 1'b0;
      else if (ctrl.relAll) chanAckN <= 1'b1;
      if (ctrl.setPortWr) portWrStbN <= 1'b0;
      else if (ctrl.relAll) portWrStbN <= 1'b1;
      if (ctrl.setPortRd) portRdStbN <= 1'b0;
      else if (ctrl.relAll) portRdStbN <= 1'b1;
      if (ctrl.setErr)      timeoutErr <= 1'b1;
      else if (ctrl.clrErr) timeoutErr <= 1'b0;
    end
  end

  always_comb begin
    stat.reqActive    = reqSampled;
    stat.bypassOk     = !reqSampled && (relCnt == REL_SAT);
    stat.timerAtLimit = (waitTimer == T_LIM);
    stat.isRead       = rdMode;
  end

endmodule

// File: rtl/dmaPortHandshake_ctl.sv
module dmaPortHandshake_ctl
  import dmaPortHandshake_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cycStart,
  input  logic    memReadyN,
  input  logic    timeoutDisN,
  input  hsStat_t stat,
  output hsCtrl_t ctrl
);

  hsState_e state, nxtState;
  logic     waiting;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  always_comb begin
    nxtState = state;
    ctrl     = '0;
    waiting  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cycStart) begin
          nxtState      = ST_ADDR;
          ctrl.setAck   = 1'b1;
          ctrl.clrTimer = 1'b1;
          ctrl.clrErr   = 1'b1;
          ctrl.latchDir = 1'b1;
        end
      end
      ST_ADDR: begin
        nxtState = (stat.isRead || stat.bypassOk) ? ST_WAIT : ST_WREQ;
      end
      ST_WAIT: begin
        if (!memReadyN) begin
          if (stat.isRead && !stat.bypassOk) begin
            nxtState       = ST_HOLD;
            ctrl.setPortWr = 1'b1;
          end else begin
            nxtState       = ST_IDLE;
            ctrl.relAll    = 1'b1;
            ctrl.pulseDone = 1'b1;
          end
        end else begin
          waiting = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!stat.reqActive) begin
          nxtState       = ST_IDLE;
          ctrl.relAll    = 1'b1;
          ctrl.pulseDone = 1'b1;
        end else begin
          waiting = 1'b1;
        end
      end
      ST_WREQ: begin
        if (!stat.reqActive) begin
          nxtState       = ST_WAIT;
          ctrl.setPortRd = 1'b1;
        end else begin
          waiting = 1'b1;
        end
      end
      default: nxtState = ST_IDLE;
    endcase

    if (waiting) begin
      if (stat.timerAtLimit && timeoutDisN) begin
        nxtState    = ST_IDLE;
        ctrl.relAll = 1'b1;
        ctrl.setErr = 1'b1;
      end else begin
        ctrl.incTimer = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dmaPortHandshake.sv
module dmaPortHandshake
  import dmaPortHandshake_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 256,
  parameter int BYPASS_CLKS  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cycStart,
  input  logic memRead,
  input  logic chanReqN,
  input  logic memReadyN,
  input  logic timeoutDisN,
  output logic chanAckN,
  output logic portWrStbN,
  output logic portRdStbN,
  output logic cycleDone,
  output logic timeoutErr
);

  hsCtrl_t ctrl;
  hsStat_t stat;

  dmaPortHandshake_ctl i_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .cycStart    (cycStart),
    .memReadyN   (memReadyN),
    .timeoutDisN (timeoutDisN),
    .stat        (stat),
    .ctrl        (ctrl)
  );

  dmaPortHandshake_dp #(
    .TIMEOUT_CLKS (TIMEOUT_CLKS),
    .BYPASS_CLKS  (BYPASS_CLKS)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .chanReqN    (chanReqN),
    .memRead     (memRead),
    .timeoutDisN (timeoutDisN),
    .ctrl        (ctrl),
    .stat        (stat),
    .chanAckN    (chanAckN),
    .portWrStbN  (portWrStbN),
    .portRdStbN  (portRdStbN),
    .cycleDone   (cycleDone),
    .timeoutErr  (timeoutErr)
  );

endmodule

// File: rtl/dmaPortHandshake_chk.sv
module dmaPortHandshake_chk (
  input logic clk,
  input logic rstN,
  input logic cycStart,
  input logic memReadyN,
  input logic timeoutDisN,
  input logic chanAckN,
  input logic portWrStbN,
  input logic portRdStbN,
  input logic cycleDone,
  input logic timeoutErr
);

  p_ack_on_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    cycStart && chanAckN |=> !chanAckN);

  p_wrstb_in_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    !portWrStbN |-> !chanAckN);

  p_wrstb_after_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(portWrStbN) |-> !$past(memReadyN));

  p_done_releases_r4: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> chanAckN && portWrStbN && portRdStbN);

  p_rdstb_in_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    !portRdStbN |-> !chanAckN);

  p_strobes_apart_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(!portWrStbN && !portRdStbN));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);

  p_ack_rise_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chanAckN) |-> cycleDone || timeoutErr);

  p_abort_clean_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> chanAckN && !cycleDone);

  p_no_to_disabled_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> $past(timeoutDisN));

endmodule

bind dmaPortHandshake dmaPortHandshake_chk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cycStart    (cycStart),
  .memReadyN   (memReadyN),
  .timeoutDisN (timeoutDisN),
  .chanAckN    (chanAckN),
  .portWrStbN  (portWrStbN),
  .portRdStbN  (portRdStbN),
  .cycleDone   (cycleDone),
  .timeoutErr  (timeoutErr)
);

// File: tb/test_dmaPortHandshake.sv
`timescale 1ns/1ps
module test_dmaPortHandshake;

  localparam int LIMIT = 256;

  logic clk = 1'b0;
  logic rstN, cycStart, memRead, chanReqN, memReadyN, timeoutDisN;
  logic chanAckN, portWrStbN, portRdStbN, cycleDone, timeoutErr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // reference state
  int mState;  // 0 idle 1 addr 2 wait 3 hold 4 wreq
  int mTimer;
  bit mRel, mRd;
  bit eAck, eWr, eRd, eDone, eErr;
  // scenario observations
  int sawWr, sawRd, doneCnt, errSeen, doneTick, tickNo;

  always #4 clk = ~clk;

  dmaPortHandshake i_dmaPortHandshake (
    .clk(clk), .rstN(rstN), .cycStart(cycStart), .memRead(memRead),
    .chanReqN(chanReqN), .memReadyN(memReadyN), .timeoutDisN(timeoutDisN),
    .chanAckN(chanAckN), .portWrStbN(portWrStbN), .portRdStbN(portRdStbN),
    .cycleDone(cycleDone), .timeoutErr(timeoutErr)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishCycle();
    mState = 0; eAck = 1; eWr = 1; eRd = 1; eDone = 1;
  endtask

  // expected state after the next rising edge, derived from R2..R10
  task automatic modelStep(input bit s, input bit reqAct, input bit rdyLow,
                           input bit td, input bit dir);
    bit byp, waitE;
    byp = !reqAct && mRel;
    waitE = 0;
    eDone = 0;
    case (mState)
      0: if (s) begin
           mState = 1; eAck = 0; mTimer = 0; eErr = 0; mRd = dir;
         end
      1: mState = (mRd || byp) ? 2 : 4;
      2: if (rdyLow) begin
           if (mRd && !byp) begin mState = 3; eWr = 0; end
           else finishCycle();
         end else waitE = 1;
      3: if (!reqAct) finishCycle(); else waitE = 1;
      4: if (!reqAct) begin mState = 2; eRd = 0; end else waitE = 1;
      default: mState = 0;
    endcase
    if (waitE) begin
      if (mTimer == LIMIT && td) begin
        mState = 0; eAck = 1; eWr = 1; eRd = 1; eErr = 1;
      end else mTimer = mTimer + 1;
    end
    if (!td) mTimer = 0;
    mRel = !reqAct;
  endtask

  task automatic tick(input bit s, input bit rq, input bit rdy,
                      input bit td, input bit dir);
    cycStart = s; chanReqN = rq; memReadyN = rdy; timeoutDisN = td; memRead = dir;
    modelStep(s, !rq, !rdy, td, dir);
    @(posedge clk);
    #3;
    tickNo++;
    check("R2 chanAckN", chanAckN, eAck);
    check("R3 portWrStbN", portWrStbN, eWr);
    check("R5 portRdStbN", portRdStbN, eRd);
    check("R7 cycleDone", cycleDone, eDone);
    check("R8 timeoutErr", timeoutErr, eErr);
    if (!portWrStbN) sawWr++;
    if (!portRdStbN) sawRd++;
    if (cycleDone) begin doneCnt++; doneTick = tickNo; end
    if (timeoutErr) errSeen = 1;
  endtask

  // one cycle: request held low for ticks < relAt, ready low from tick rdyAt
  task automatic doCycle(input bit dir, input int relAt, input int rdyAt,
                         input bit td, input bit dupStart, input int len);
    sawWr = 0; sawRd = 0; doneCnt = 0; errSeen = 0; doneTick = -1; tickNo = -1;
    for (int i = 0; i < len; i++)
      tick((i == 0) || (dupStart && i == 1), (i < relAt) ? 1'b0 : 1'b1,
           (i >= rdyAt) ? 1'b0 : 1'b1, td, dir);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, 1'b1, 1'b1, dir);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 0; cycStart = 0; memRead = 1; chanReqN = 1; memReadyN = 1; timeoutDisN = 1;
    mState = 0; mTimer = 0; mRel = 0; mRd = 1;
    eAck = 1; eWr = 1; eRd = 1; eDone = 0; eErr = 0;
    repeat (3) @(posedge clk);
    #3;
    check("R1 reset chanAckN", chanAckN, 1);
    check("R1 reset portWrStbN", portWrStbN, 1);
    check("R1 reset portRdStbN", portRdStbN, 1);
    check("R1 reset cycleDone", cycleDone, 0);
    check("R1 reset timeoutErr", timeoutErr, 0);
    rstN = 1;
    tick(0, 1, 1, 1, 1);

    // R3/R4 read handshake: ready at tick 4, request released at tick 8
    doCycle(1, 8, 4, 1, 0, 12);
    check("R3 read handshake strobe seen", sawWr > 0, 1);
    check("R4 read ends on request release", doneTick, 8);

    // R6 boundary: released 2 samples before ready edge -> bypass
    doCycle(1, 3, 4, 1, 0, 8);
    check("R6 bypass no strobe", sawWr, 0);
    check("R6 bypass ends on ready", doneTick, 4);
    // released only 1 sample before -> handshake kept
    doCycle(1, 4, 4, 1, 0, 8);
    check("R6 one-clock release keeps handshake", sawWr, 1);
    check("R4 release already seen ends next edge", doneTick, 5);

    // R10 software cycle, no request, ready already low
    doCycle(1, 0, 0, 1, 0, 4);
    check("R10 shortest cycle done edge", doneTick, 2);
    check("R7 single done pulse", doneCnt, 1);

    // R5 write handshake
    doCycle(0, 5, 0, 1, 0, 9);
    check("R5 write capture strobe seen", sawRd, 1);
    check("R5 write done after strobe", doneTick, 6);
    // R6 write bypass
    doCycle(0, 0, 3, 1, 0, 6);
    check("R6 write bypass no strobe", sawRd, 0);
    check("R6 write bypass done", doneTick, 3);

    // R2 duplicate start ignored
    doCycle(1, 6, 3, 1, 1, 9);
    check("R2 extra start no second done", doneCnt, 1);

    // R8 boundary: 256 waiting edges completes, 257 aborts
    doCycle(1, 0, 258, 1, 0, 262);
    check("R8 256 waits no error", errSeen, 0);
    check("R8 256 waits completes", doneCnt, 1);
    doCycle(1, 0, 259, 1, 0, 262);
    check("R8 257 waits raises error", errSeen, 1);
    check("R8 abort gives no done", doneCnt, 0);
    check("R8 error held", timeoutErr, 1);
    doCycle(0, 300, 0, 1, 0, 302);
    check("R8 write request stall error", errSeen, 1);

    // R9 timeout disabled
    doCycle(1, 0, 320, 0, 0, 324);
    check("R9 no error while disabled", errSeen, 0);
    check("R9 cycle completes", doneCnt, 1);

    // seeded random cycles
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 60; n++) begin
      int rel, rdy, len;
      bit dir, td, dup;
      dir = $urandom_range(0, 1);
      rel = $urandom_range(0, 9);
      rdy = $urandom_range(0, 8);
      td  = ($urandom_range(0, 9) != 0);
      dup = ($urandom_range(0, 3) == 0);
      len = rel + rdy + 5;
      doCycle(dir, rel, rdy, td, dup, len);
      check("R7 random cycle one done", doneCnt, 1);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule